// File: doc/BRIEF.md
# Corrected-Error Threshold Interrupt Unit

This unit serves one error bank. It counts the corrected errors that the bank reports and raises an interrupt request toward the local interrupt controller once the count reaches a threshold that software sets. Software sees two 64-bit words. The control word holds the threshold and a signaling enable. The status word holds the running error count. Writing the status word loads the count, and writing zero clears it. The interrupt request is a single-cycle registered pulse.

Two build-time switches decide whether thresholding and signaling exist. When a feature is absent, its bits cannot be set. Software can therefore probe for a feature by writing it and reading it back: a field that reads back as zero is not implemented. The unit has no inputs for machine-check enable or per-bank error reporting enable. Interrupt generation therefore cannot depend on them.

Top module: `cethr_unit`

## Requirements
- R1: After a synchronous reset, both words read zero, the signaling enable is off and the interrupt output is low.
- R2: A control write keeps bits 14:0 (threshold) and bit 30 (enable) when both features are built in. Every other control bit reads zero. The control word holds its value until the next control write.
- R3: When thresholding is not built in, control bits 14:0 read back as zero after any write.
- R4: When signaling is not built in, control bit 30 reads back as zero after software writes 1, and the interrupt output never goes high.
- R5: Each cycle with the error event high and no status write adds one to the count. The count is visible in status bits 52:38 on the cycle after the event.
- R6: The count saturates at 0x7FFF. An event at the maximum leaves the count unchanged and raises no interrupt.
- R7: When the enable is 1 and an event takes the count from threshold-1 to the threshold, the interrupt output is high for exactly the one cycle after that event.
- R8: With the enable at 0, reaching the threshold raises no interrupt.
- R9: A threshold of zero never raises an interrupt.
- R10: Once the interrupt has fired, further events do not fire it again. After software writes a count below the threshold to the status word, reaching the threshold again fires it again. Loading a count equal to the threshold does not fire.
- R11: If an error event arrives in the same cycle as a status write, the event is dropped and the count equals the written value.
- R12: A status write loads the count from bits 52:38 of the written data. All other status bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | Target of the write: 0 selects control, 1 selects status |
| reg_wdata | input | 64 | Write data |
| ctl_rdata | output | 64 | Control word read value |
| sts_rdata | output | 64 | Status word read value |
| ce_event | input | 1 | One corrected error reported in this cycle |
| irq_pulse | output | 1 | One-cycle interrupt request toward the local vector entry |

## Verification
The bench targets five corner cases:
- **Rising past the threshold.** A design that compares the count as a level would fire again on every later event, or when the count is loaded to equal the threshold.
- **Saturation.** With the threshold at 0x7FFF, a wrapping counter would return to zero, and a level compare would fire on each event at the maximum.
- **Collision of an event with a status write.** A design that lets the event win would show the written value plus one.
- **Threshold of zero.** A design that treats zero as a real threshold would fire right after the count is cleared.
- **Build-time switches.** A second instance has both features left out. Its control word must read zero after an all-ones write, and its interrupt must stay low for the whole run; a design that ignored the switches would keep the bits.

// File: rtl/cethr_pkg.sv
package cethr_pkg;
  localparam int REG_W   = 64;
  localparam int THR_W   = 15;
  localparam int THR_LSB = 0;
  localparam int EN_BIT  = 30;
  localparam int CNT_W   = 15;
  localparam int CNT_LSB = 38;

  typedef enum logic {
    SEL_CTL = 1'b0,
    SEL_STS = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/cethr_ctl_reg.sv
module cethr_ctl_reg
  import cethr_pkg::*;
#(
  parameter int REG_W_P    = REG_W,
  parameter int THR_W_P    = THR_W,
  parameter int THR_LSB_P  = THR_LSB,
  parameter int EN_BIT_P   = EN_BIT,
  parameter bit HAS_THRESH = 1'b1,
  parameter bit HAS_SIGNAL = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [THR_W_P-1:0] thr_wr,
  input  logic               en_wr,
  output logic [THR_W_P-1:0] thr,
  output logic               en,
  output logic [REG_W_P-1:0] rdata
);
  localparam logic [THR_W_P-1:0] THR_MASK = HAS_THRESH ? {THR_W_P{1'b1}} : '0;

  // threshold field, present only when thresholding is built in
  generate
    if (HAS_THRESH) begin : g_thr
      logic [THR_W_P-1:0] thr_q;
      always_ff @(posedge clk) begin
        if (rst)        thr_q <= '0;
        else if (wr_en) thr_q <= thr_wr;
      end
      assign thr = thr_q;
    end else begin : g_no_thr
      logic unused_thr;
      assign unused_thr = ^thr_wr;
      assign thr = '0;
    end
  endgenerate

  // signaling enable, present only when signaling is built in
  generate
    if (HAS_SIGNAL) begin : g_sig
      logic en_q;
      always_ff @(posedge clk) begin
        if (rst)        en_q <= 1'b0;
        else if (wr_en) en_q <= en_wr;
      end
      assign en = en_q;
    end else begin : g_no_sig
      logic unused_en;
      assign unused_en = en_wr;
      assign en = 1'b0;
    end
  endgenerate

  always_comb begin
    rdata = '0;
    rdata[THR_LSB_P +: THR_W_P] = thr;
    rdata[EN_BIT_P] = en;
  end

  AST_CTL_KEEP: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> thr == ($past(thr_wr) & THR_MASK)); // R2
  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(rdata)); // R2
  AST_SIG_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> en == ($past(en_wr) && HAS_SIGNAL)); // R4
endmodule

// File: rtl/cethr_err_cnt.sv
module cethr_err_cnt
  import cethr_pkg::*;
#(
  parameter int CNT_W_P = CNT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ev,
  input  logic               ld,
  input  logic [CNT_W_P-1:0] ld_val,
  output logic [CNT_W_P-1:0] cnt,
  output logic               step
);
  localparam logic [CNT_W_P-1:0] CNT_MAX = {CNT_W_P{1'b1}};
  localparam logic [CNT_W_P-1:0] ONE     = CNT_W_P'(1);

  logic [CNT_W_P-1:0] cnt_q;

  // a software load wins over a coincident event; saturate at the top
  assign step = ev && !ld && (cnt_q != CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (ld)   cnt_q <= ld_val;
    else if (step) cnt_q <= cnt_q + ONE;
  end

  assign cnt = cnt_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (ev && !ld && cnt != CNT_MAX) |=> cnt == $past(cnt) + ONE); // R5
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (rst)
    (ev && !ld && cnt == CNT_MAX) |=> cnt == CNT_MAX); // R6
  AST_LD_WINS: assert property (@(posedge clk) disable iff (rst)
    ld |=> cnt == $past(ld_val)); // R11
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!ev && !ld) |=> $stable(cnt)); // R5
endmodule

// File: rtl/cethr_irq_gen.sv
module cethr_irq_gen
  import cethr_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] thr,
  input  logic [W-1:0] cnt,
  input  logic         step,
  output logic         irq
);
  localparam logic [W-1:0] ONE = W'(1);

  logic hit;
  logic irq_q;

  // fire only on the increment that lands on the threshold
  assign hit = en && (thr != '0) && step && ((cnt + ONE) == thr);

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= hit;
  end

  assign irq = irq_q;

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq); // R7
  AST_IRQ_AT_THR: assert property (@(posedge clk) disable iff (rst)
    irq |-> cnt == $past(thr)); // R7
  AST_IRQ_NEED_EN: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(en)); // R8
  AST_IRQ_THR_NZ: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(thr) != '0); // R9
  AST_IRQ_NEED_STEP: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(step)); // R10
endmodule

// File: rtl/cethr_unit.sv
module cethr_unit
  import cethr_pkg::*;
#(
  parameter bit HAS_THRESH = 1'b1,
  parameter bit HAS_SIGNAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr_en,
  input  logic             reg_wr_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] ctl_rdata,
  output logic [REG_W-1:0] sts_rdata,
  input  logic             ce_event,
  output logic             irq_pulse
);
  localparam logic [REG_W-1:0] USED_MASK =
    ({{(REG_W-THR_W){1'b0}}, {THR_W{1'b1}}} << THR_LSB) |
    ({{(REG_W-1){1'b0}}, 1'b1} << EN_BIT) |
    ({{(REG_W-CNT_W){1'b0}}, {CNT_W{1'b1}}} << CNT_LSB);

  reg_sel_e         sel;
  logic             ctl_wr;
  logic             sts_wr;
  logic [THR_W-1:0] thr;
  logic             en;
  logic [CNT_W-1:0] cnt;
  logic             step;
  logic             unused_wbits;

  assign sel    = reg_sel_e'(reg_wr_sel);
  assign ctl_wr = reg_wr_en && (sel == SEL_CTL);
  assign sts_wr = reg_wr_en && (sel == SEL_STS);
  assign unused_wbits = ^(reg_wdata & ~USED_MASK);

  cethr_ctl_reg #(
    .REG_W_P(REG_W), .THR_W_P(THR_W), .THR_LSB_P(THR_LSB), .EN_BIT_P(EN_BIT),
    .HAS_THRESH(HAS_THRESH), .HAS_SIGNAL(HAS_SIGNAL)
  ) u_ctl (
    .clk(clk), .rst(rst), .wr_en(ctl_wr),
    .thr_wr(reg_wdata[THR_LSB +: THR_W]), .en_wr(reg_wdata[EN_BIT]),
    .thr(thr), .en(en), .rdata(ctl_rdata)
  );

  cethr_err_cnt #(.CNT_W_P(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .ev(ce_event), .ld(sts_wr),
    .ld_val(reg_wdata[CNT_LSB +: CNT_W]), .cnt(cnt), .step(step)
  );

  cethr_irq_gen #(.W(CNT_W)) u_irq (
    .clk(clk), .rst(rst), .en(en), .thr(thr), .cnt(cnt), .step(step),
    .irq(irq_pulse)
  );

  always_comb begin
    sts_rdata = '0;
    sts_rdata[CNT_LSB +: CNT_W] = cnt;
  end

  AST_STS_LOAD: assert property (@(posedge clk) disable iff (rst)
    sts_wr |=> sts_rdata == ($past(reg_wdata) & (USED_MASK & ~(USED_MASK & 64'h7FFF_FFFF)))); // R12
endmodule

// File: tb/cethr_unit_tb.sv
module cethr_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic        reg_wr_sel = 1'b0;
  logic [63:0] reg_wdata = '0;
  logic        ce_event = 1'b0;
  logic [63:0] ctl_rdata, sts_rdata, ctl_bare, sts_bare;
  logic        irq_pulse, irq_bare;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  bit bare_irq_seen = 1'b0;

  always #5 clk = ~clk;

  cethr_unit u_dut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
    .reg_wdata(reg_wdata), .ctl_rdata(ctl_rdata), .sts_rdata(sts_rdata),
    .ce_event(ce_event), .irq_pulse(irq_pulse)
  );

  cethr_unit #(.HAS_THRESH(1'b0), .HAS_SIGNAL(1'b0)) u_dut_bare (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
    .reg_wdata(reg_wdata), .ctl_rdata(ctl_bare), .sts_rdata(sts_bare),
    .ce_event(ce_event), .irq_pulse(irq_bare)
  );

  always @(posedge clk) if (!rst && irq_bare) bare_irq_seen <= 1'b1;

  // entry: op[33:32] (0 event, 1 ctl write, 2 sts write, 3 idle),
  // data[31:16] (bit 15 = enable, 14:0 = value), exp count[15:1], exp irq[0]
  localparam int NV = 25;
  localparam logic [33:0] TBL [0:NV-1] = '{
    {2'd1, 16'h8003, 15'd0, 1'b0},
    {2'd0, 16'h0000, 15'd1, 1'b0},
    {2'd0, 16'h0000, 15'd2, 1'b0},
    {2'd0, 16'h0000, 15'd3, 1'b1},
    {2'd3, 16'h0000, 15'd3, 1'b0},
    {2'd0, 16'h0000, 15'd4, 1'b0},
    {2'd2, 16'h0000, 15'd0, 1'b0},
    {2'd0, 16'h0000, 15'd1, 1'b0},
    {2'd0, 16'h0000, 15'd2, 1'b0},
    {2'd0, 16'h0000, 15'd3, 1'b1},
    {2'd1, 16'h0003, 15'd3, 1'b0},
    {2'd2, 16'h0000, 15'd0, 1'b0},
    {2'd0, 16'h0000, 15'd1, 1'b0},
    {2'd0, 16'h0000, 15'd2, 1'b0},
    {2'd0, 16'h0000, 15'd3, 1'b0},
    {2'd1, 16'h8000, 15'd3, 1'b0},
    {2'd2, 16'h0000, 15'd0, 1'b0},
    {2'd0, 16'h0000, 15'd1, 1'b0},
    {2'd1, 16'h8002, 15'd1, 1'b0},
    {2'd0, 16'h0000, 15'd2, 1'b1},
    {2'd2, 16'h0001, 15'd1, 1'b0},
    {2'd0, 16'h0000, 15'd2, 1'b1},
    {2'd1, 16'h8005, 15'd2, 1'b0},
    {2'd2, 16'h0005, 15'd5, 1'b0},
    {2'd0, 16'h0000, 15'd6, 1'b0}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one operation, let one edge take it, sample 2 ns after that edge
  task automatic apply(input logic [1:0] op, input logic [15:0] dat, input logic ev_also);
    reg_wr_en  = (op == 2'd1) || (op == 2'd2);
    reg_wr_sel = (op == 2'd2);
    reg_wdata  = '0;
    if (op == 2'd1) begin
      reg_wdata[14:0] = dat[14:0];
      reg_wdata[30]   = dat[15];
    end else if (op == 2'd2) begin
      reg_wdata[52:38] = dat[14:0];
    end
    ce_event = (op == 2'd0) || ev_also;
    @(posedge clk);
    #2;
    reg_wr_en = 1'b0;
    ce_event  = 1'b0;
    reg_wdata = '0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rst = 1'b0;
    // R1: reset state
    chk("R1 ctl after reset", ctl_rdata, 64'h0);
    chk("R1 sts after reset", sts_rdata, 64'h0);
    chk("R1 irq after reset", {63'h0, irq_pulse}, 64'h0);

    // table: R5 R7 R8 R9 R10 R12
    for (int i = 0; i < NV; i++) begin
      apply(TBL[i][33:32], TBL[i][31:16], 1'b0);
      chk($sformatf("table row %0d count (R5 R10 R12)", i),
          64'(sts_rdata[52:38]), 64'(TBL[i][15:1]));
      chk($sformatf("table row %0d irq (R7 R8 R9 R10)", i),
          64'(irq_pulse), 64'(TBL[i][0]));
    end

    // R11: event coinciding with a status write is dropped
    apply(2'd2, 16'h0009, 1'b1);
    chk("R11 write beats event", 64'(sts_rdata[52:38]), 64'd9);

    // R6: saturation with threshold at maximum
    apply(2'd1, 16'hFFFF, 1'b0);
    apply(2'd2, 16'h7FFD, 1'b0);
    apply(2'd0, 16'h0, 1'b0);
    chk("R6 count 7FFE", 64'(sts_rdata[52:38]), 64'h7FFE);
    chk("R6 no irq at 7FFE", 64'(irq_pulse), 64'd0);
    apply(2'd0, 16'h0, 1'b0);
    chk("R6 count 7FFF", 64'(sts_rdata[52:38]), 64'h7FFF);
    chk("R7 irq at max threshold", 64'(irq_pulse), 64'd1);
    apply(2'd0, 16'h0, 1'b0);
    chk("R6 count held at 7FFF", 64'(sts_rdata[52:38]), 64'h7FFF);
    chk("R6 no irq when saturated", 64'(irq_pulse), 64'd0);

    // R2: reserved control bits read zero, features kept
    reg_wr_en = 1'b1; reg_wr_sel = 1'b0; reg_wdata = '1; ce_event = 1'b0;
    @(posedge clk); #2;
    reg_wr_en = 1'b0; reg_wdata = '0;
    chk("R2 ctl readback", ctl_rdata, 64'h0000_0000_4000_7FFF);
    // R3 R4: bare instance keeps nothing
    chk("R3 no threshold bits", 64'(ctl_bare[14:0]), 64'd0);
    chk("R4 no enable bit", 64'(ctl_bare[30]), 64'd0);
    apply(2'd3, 16'h0, 1'b0);
    chk("R2 ctl held", ctl_rdata, 64'h0000_0000_4000_7FFF);

    // R12: status write of all ones exposes only the count field
    reg_wr_en = 1'b1; reg_wr_sel = 1'b1; reg_wdata = '1;
    @(posedge clk); #2;
    reg_wr_en = 1'b0; reg_wdata = '0;
    chk("R12 status readback", sts_rdata, 64'(15'h7FFF) << 38);

    chk("R4 bare irq never seen", 64'(bare_irq_seen), 64'd0);

    done = 1'b1;
    finish_run();
  end
endmodule